// File: doc/BRIEF.md
# Multi-Level Routing Multiplexer with Local Select Decoders

This block is a parameterised N-input routing multiplexer for a programmable interconnect fabric. It builds the selection from a cascade of levels. Each level is a row of small branch multiplexers, and all branches in one row share that row's select field. The block derives the branch width from the input count and the level count. With the tree option set, a cascade of 2-input branches is used. A 2-input multiplexer always takes the tree form. An optional constant-zero input can be appended above the datapath inputs.

Each level is selected in one of two ways. The first is a raw one-hot field. The second is a small binary field that a per-level local decoder expands into a one-hot vector and its inverted copy, which cuts the number of stored configuration bits. The block is purely combinational. Its main path takes the data bus and the configuration word and produces the routed output.

A second combinational path turns an input index into the configuration word that routes that input. Configuration software, or a test environment, can use it to build settings.

Top module: `routing_mux`

## Requirements
- R1: The implemented input count is N_DATA plus ADD_CONST. When ADD_CONST is 1, the extra input sits at index N_DATA and always reads logic 0.
- R2: In tree mode, or whenever the implemented count is 2, the level count is ceil(log2 N) and the branch width is 2. Otherwise the level count is LEVELS. With one level the branch width is N; with more, it is the smallest k of at least 2 with k^L at least N. N_DATA below 2, or LEVELS below 1, stops elaboration.
- R3: The field for level l occupies configuration bits [l*FW +: FW], where level 0 is nearest the inputs. Input i is reached at level l through branch input digit (i / K^l) mod K.
- R4: Without local decoders, FW equals K, and bit j of a field enables branch input j.
- R5: With local decoders, FW is ceil(log2 K), with a minimum of 1, and the field holds the digit as an unsigned binary number.
- R6: For every input index, applying the configuration for that index makes data_o equal data_i at that index, whatever the other inputs hold.
- R7: A level whose select is empty drives 0 out of its branches. An empty select is a decoder address of K or more, or an all-zero one-hot field. data_o is then 0 with all data inputs high.
- R8: route_cfg_o is the configuration word of R3 to R5 for input index route_idx_i.
- R9: Each local decoder output has at most one bit set, and its inverted port is the bitwise complement of its true port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | N_DATA | Datapath inputs |
| cfg_i | input | CFG_W | Configuration word, one field per level |
| route_idx_i | input | IDX_W | Input index to be encoded |
| data_o | output | 1 | Routed output |
| route_cfg_o | output | CFG_W | Configuration word that routes route_idx_i |

## Verification
Three variants are tried:
- a two-level decoded multiplexer with a constant input and a branch width of 3, so one decoder code is unused;
- a three-level one-hot tree;
- a 2-input multiplexer forced into tree form.

For every index, the bench applies a walking one and a walking zero. These tell a misrouted digit or a swapped level from a correct route. Random data checks that unrelated inputs never leak into the output. The unused decoder code, an all-zero one-hot field and the constant input are driven with all data high, which tells a defined 0 apart from a leak of a neighbouring input.

// File: rtl/routing_mux_pkg.sv
package routing_mux_pkg;

  function automatic int ipow(input int b, input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

  function automatic int lvl_count(input int n, input bit tree, input int lreq);
    if (tree || n == 2) return $clog2(n);
    return lreq;
  endfunction

  function automatic int br_width(input int n, input int l);
    if (l <= 1) return n;
    for (int k = 2; k <= n; k++) begin
      if (ipow(k, l) >= n) return k;
    end
    return n;
  endfunction

  function automatic int fld_width(input int k, input bit dec);
    if (!dec) return k;
    return (k < 2) ? 1 : $clog2(k);
  endfunction

endpackage

// File: rtl/lvl_decoder.sv
module lvl_decoder #(
  parameter int AW = 2,
  parameter int M  = 3
) (
  input  logic [AW-1:0] addr_i,
  output logic [M-1:0]  hot_o,
  output logic [M-1:0]  hot_n_o
);
  // codes at or above M leave every line low
  always_comb begin
    for (int j = 0; j < M; j++) hot_o[j] = (int'(addr_i) == j);
  end
  assign hot_n_o = ~hot_o;
endmodule

// File: rtl/branch_mux.sv
module branch_mux #(
  parameter int K = 3
) (
  input  logic [K-1:0] in_i,
  input  logic [K-1:0] sel_i,
  input  logic [K-1:0] sel_n_i,
  output logic         out_o
);
  // a path conducts only when both complementary gates are on
  assign out_o = |(in_i & sel_i & ~sel_n_i);
endmodule

// File: rtl/route_map.sv
module route_map #(
  parameter int L     = 2,
  parameter int K     = 3,
  parameter int FW    = 2,
  parameter bit DEC   = 1'b1,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [L*FW-1:0]   cfg_o
);
  import routing_mux_pkg::*;

  always_comb begin
    cfg_o = '0;
    for (int lv = 0; lv < L; lv++) begin
      int digit;
      digit = (int'(idx_i) / ipow(K, lv)) % K;
      if (DEC) cfg_o[lv*FW +: FW] = FW'(digit);
      else     cfg_o[lv*FW +: FW] = FW'(1) << digit;
    end
  end
endmodule

// File: rtl/routing_mux.sv
module routing_mux
  import routing_mux_pkg::*;
#(
  parameter int N_DATA    = 8,
  parameter bit ADD_CONST = 1'b1,
  parameter bit TREE      = 1'b0,
  parameter int LEVELS    = 2,
  parameter bit USE_DEC   = 1'b1,
  localparam int N_IMPL   = N_DATA + int'(ADD_CONST),
  localparam int NUM_LVL  = lvl_count(N_IMPL, TREE, LEVELS),
  localparam int BR_W     = (TREE || N_IMPL == 2) ? 2 : br_width(N_IMPL, NUM_LVL),
  localparam int FW       = fld_width(BR_W, USE_DEC),
  localparam int CFG_W    = NUM_LVL * FW,
  localparam int IDX_W    = $clog2(N_IMPL)
) (
  input  logic [N_DATA-1:0] data_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [IDX_W-1:0]  route_idx_i,
  output logic              data_o,
  output logic [CFG_W-1:0]  route_cfg_o
);
  localparam int SLOTS = ipow(BR_W, NUM_LVL);

  if (N_DATA < 2) begin : g_bad_size
    $error("routing_mux: N_DATA must be at least 2");
  end
  if (NUM_LVL < 1) begin : g_bad_lvl
    $error("routing_mux: level count must be at least 1");
  end
  if (BR_W < 2) begin : g_bad_width
    $error("routing_mux: branch width below 2");
  end

  // constant input and padding slots read 0
  logic [SLOTS-1:0]           slot_vec;
  logic [NUM_LVL*BR_W-1:0]    sel_hot;
  logic [NUM_LVL*BR_W-1:0]    sel_hot_n;

  always_comb begin
    slot_vec = '0;
    slot_vec[N_DATA-1:0] = data_i;
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    localparam int NI = SLOTS / ipow(BR_W, l);
    localparam int NB = NI / BR_W;
    logic [NI-1:0] lvl_in;
    logic [NB-1:0] lvl_out;

    if (l == 0) begin : g_first
      assign lvl_in = slot_vec;
    end else begin : g_next
      assign lvl_in = g_lvl[l-1].lvl_out;
    end

    if (USE_DEC) begin : g_dec
      lvl_decoder #(.AW(FW), .M(BR_W)) dec_i (
        .addr_i (cfg_i[l*FW +: FW]),
        .hot_o  (sel_hot[l*BR_W +: BR_W]),
        .hot_n_o(sel_hot_n[l*BR_W +: BR_W])
      );
    end else begin : g_raw
      assign sel_hot[l*BR_W +: BR_W]   = cfg_i[l*FW +: FW];
      assign sel_hot_n[l*BR_W +: BR_W] = ~cfg_i[l*FW +: FW];
    end

    for (genvar b = 0; b < NB; b++) begin : g_br
      branch_mux #(.K(BR_W)) br_i (
        .in_i   (lvl_in[b*BR_W +: BR_W]),
        .sel_i  (sel_hot[l*BR_W +: BR_W]),
        .sel_n_i(sel_hot_n[l*BR_W +: BR_W]),
        .out_o  (lvl_out[b])
      );
    end
  end

  assign data_o = g_lvl[NUM_LVL-1].lvl_out[0];

  route_map #(
    .L(NUM_LVL), .K(BR_W), .FW(FW), .DEC(USE_DEC), .IDX_W(IDX_W)
  ) map_i (
    .idx_i(route_idx_i),
    .cfg_o(route_cfg_o)
  );
endmodule

// File: rtl/routing_mux_chk.sv
module routing_mux_chk #(
  parameter int N_DATA    = 8,
  parameter bit ADD_CONST = 1'b1,
  parameter bit USE_DEC   = 1'b1,
  parameter int L         = 2,
  parameter int K         = 3,
  parameter int CFG_W     = 4,
  parameter int IDX_W     = 4
) (
  input logic [N_DATA-1:0] data_i,
  input logic [CFG_W-1:0]  cfg_i,
  input logic [IDX_W-1:0]  route_idx_i,
  input logic              data_o,
  input logic [CFG_W-1:0]  route_cfg_o,
  input logic [L*K-1:0]    sel_hot,
  input logic [L*K-1:0]    sel_hot_n
);
  always_comb begin
    if (!$isunknown({data_i, cfg_i, route_idx_i})) begin
      for (int l = 0; l < L; l++) begin
        if (USE_DEC) begin
          assert_dec_onehot_R9: assert ($onehot0(sel_hot[l*K +: K]))
            else $error("decoder output of level %0d not one-hot", l);
        end
        assert_dec_inv_R9: assert (sel_hot_n[l*K +: K] == ~sel_hot[l*K +: K])
          else $error("inverted select of level %0d not complementary", l);
        if (sel_hot[l*K +: K] == '0) begin
          assert_empty_sel_R7: assert (data_o == 1'b0)
            else $error("empty select on level %0d but output high", l);
        end
      end
      if (cfg_i == route_cfg_o && int'(route_idx_i) < N_DATA) begin
        assert_route_R6: assert (data_o == data_i[route_idx_i])
          else $error("route to %0d gave wrong data", route_idx_i);
      end
      if (ADD_CONST && cfg_i == route_cfg_o && int'(route_idx_i) == N_DATA) begin
        assert_const_R1: assert (data_o == 1'b0)
          else $error("constant input not zero");
      end
    end
  end
endmodule

bind routing_mux routing_mux_chk #(
  .N_DATA(N_DATA), .ADD_CONST(ADD_CONST), .USE_DEC(USE_DEC),
  .L(NUM_LVL), .K(BR_W), .CFG_W(CFG_W), .IDX_W(IDX_W)
) chk_i (
  .data_i(data_i), .cfg_i(cfg_i), .route_idx_i(route_idx_i),
  .data_o(data_o), .route_cfg_o(route_cfg_o),
  .sel_hot(sel_hot), .sel_hot_n(sel_hot_n)
);

// File: tb/routing_mux_tb_top.sv
module routing_mux_tb_top;
  // variant A: 8 data + const, 2 levels, decoded, K=3, FW=2
  localparam int A_ND = 8, A_N = 9, A_K = 3, A_L = 2, A_FW = 2, A_CW = 4, A_IW = 4;
  // variant B: 5 data, tree, one-hot, K=2, L=3, FW=2
  localparam int B_ND = 5, B_N = 5, B_K = 2, B_L = 3, B_FW = 2, B_CW = 6, B_IW = 3;
  // variant C: 2 data, forced tree, decoded, K=2, L=1, FW=1
  localparam int C_ND = 2, C_N = 2, C_K = 2, C_L = 1, C_FW = 1, C_CW = 1, C_IW = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [A_ND-1:0] a_data = '0;
  logic [A_CW-1:0] a_cfg  = '0;
  logic [A_IW-1:0] a_idx  = '0;
  logic            a_out;
  logic [A_CW-1:0] a_rcfg;

  logic [B_ND-1:0] b_data = '0;
  logic [B_CW-1:0] b_cfg  = '0;
  logic [B_IW-1:0] b_idx  = '0;
  logic            b_out;
  logic [B_CW-1:0] b_rcfg;

  logic [C_ND-1:0] c_data = '0;
  logic [C_CW-1:0] c_cfg  = '0;
  logic [C_IW-1:0] c_idx  = '0;
  logic            c_out;
  logic [C_CW-1:0] c_rcfg;

  routing_mux #(.N_DATA(A_ND), .ADD_CONST(1'b1), .TREE(1'b0), .LEVELS(2), .USE_DEC(1'b1)) dut_i (
    .data_i(a_data), .cfg_i(a_cfg), .route_idx_i(a_idx), .data_o(a_out), .route_cfg_o(a_rcfg));

  routing_mux #(.N_DATA(B_ND), .ADD_CONST(1'b0), .TREE(1'b1), .LEVELS(2), .USE_DEC(1'b0)) dut_b_i (
    .data_i(b_data), .cfg_i(b_cfg), .route_idx_i(b_idx), .data_o(b_out), .route_cfg_o(b_rcfg));

  routing_mux #(.N_DATA(C_ND), .ADD_CONST(1'b0), .TREE(1'b0), .LEVELS(3), .USE_DEC(1'b1)) dut_c_i (
    .data_i(c_data), .cfg_i(c_cfg), .route_idx_i(c_idx), .data_o(c_out), .route_cfg_o(c_rcfg));

  function automatic int ref_cfg(int idx, int k, int l, int fw, bit dec);
    int r = 0;
    int p = 1;
    for (int lv = 0; lv < l; lv++) begin
      int d = (idx / p) % k;
      r = r | ((dec ? d : (1 << d)) << (lv * fw));
      p = p * k;
    end
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_a(int idx, logic [A_ND-1:0] d, string req);
    @(posedge clk); #1;
    a_data = d; a_idx = A_IW'(idx); a_cfg = A_CW'(ref_cfg(idx, A_K, A_L, A_FW, 1'b1));
    @(negedge clk);
    chk({req, " route cfg R8"}, int'(a_rcfg), ref_cfg(idx, A_K, A_L, A_FW, 1'b1));
    chk(req, int'(a_out), (idx < A_ND) ? int'(d[idx]) : 0);
  endtask

  task automatic run_b(int idx, logic [B_ND-1:0] d, string req);
    @(posedge clk); #1;
    b_data = d; b_idx = B_IW'(idx); b_cfg = B_CW'(ref_cfg(idx, B_K, B_L, B_FW, 1'b0));
    @(negedge clk);
    chk({req, " route cfg R8"}, int'(b_rcfg), ref_cfg(idx, B_K, B_L, B_FW, 1'b0));
    chk(req, int'(b_out), int'(d[idx]));
  endtask

  task automatic run_c(int idx, logic [C_ND-1:0] d, string req);
    @(posedge clk); #1;
    c_data = d; c_idx = C_IW'(idx); c_cfg = C_CW'(ref_cfg(idx, C_K, C_L, C_FW, 1'b1));
    @(negedge clk);
    chk({req, " route cfg R8"}, int'(c_rcfg), ref_cfg(idx, C_K, C_L, C_FW, 1'b1));
    chk(req, int'(c_out), int'(d[idx]));
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // initial state: all-zero inputs give 0 (R7 empty one-hot in B)
    @(negedge clk);
    chk("R7 idle B", int'(b_out), 0);
    chk("R6 idle A", int'(a_out), 0);

    // R2 R3 R5: explicit digit layout for A, input 7 -> digits 1,2
    chk("R2 R3 R5 layout", ref_cfg(7, A_K, A_L, A_FW, 1'b1), 4'b1001);

    for (int i = 0; i < A_ND; i++) begin
      run_a(i, A_ND'(1) << i, "R6 walking one A");
      run_a(i, ~(A_ND'(1) << i), "R6 walking zero A");
      for (int r = 0; r < 3; r++) run_a(i, A_ND'($urandom), "R6 random A");
    end
    run_a(A_ND, '1, "R1 const input A");

    // R7 R9: unused decoder code 3 on each level
    @(posedge clk); #1; a_data = '1; a_cfg = 4'b0011;
    @(negedge clk); chk("R7 R9 bad code level0", int'(a_out), 0);
    @(posedge clk); #1; a_cfg = 4'b1100;
    @(negedge clk); chk("R7 R9 bad code level1", int'(a_out), 0);

    for (int i = 0; i < B_ND; i++) begin
      run_b(i, B_ND'(1) << i, "R4 R6 walking one B");
      run_b(i, ~(B_ND'(1) << i), "R4 R6 walking zero B");
      run_b(i, B_ND'($urandom), "R2 R6 random B");
    end
    @(posedge clk); #1; b_data = '1; b_cfg = 6'b01_00_01;
    @(negedge clk); chk("R7 empty one-hot B", int'(b_out), 0);

    for (int i = 0; i < C_ND; i++) begin
      run_c(i, C_ND'(1) << i, "R2 R5 forced tree C");
      run_c(i, ~(C_ND'(1) << i), "R2 R6 forced tree C");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule